// File: doc/BRIEF.md
# Run/Literal RLE Pixel Decoder

This block turns a byte stream of run-length encoded 8-bit graphics into a stream of pixels. Each pixel carries a transparency flag and line/image markers. The stream opens with the shape's width and height. Spans of two kinds follow:

- A solid run repeats a single colour byte.
- A literal span passes through a counted series of individual pixel bytes.

Bytes enter through a valid/ready port and pixels leave through another. Back-pressure on the pixel side stalls the decoder without losing or repeating any byte.

A consumer, such as a blitter or a layer fetch unit, pulses `start` and then streams the encoded shape in. It receives exactly width × height pixels. `pix_eol` marks the last pixel of each line and `pix_eoi` marks the last pixel of the shape. After that, `done` stays high and surplus bytes are swallowed until the next `start`.

Top module: `rle_pix_decoder`

## Requirements
- R1: After reset or `start`, the first four accepted bytes form the header: width low byte, width high byte, height low byte, height high byte (little-endian). No pixel is emitted while the header is being read.
- R2: A control byte with bit 7 = 0 is a run. Its bits 6:0 give a length L, where 0 means 128. The next byte is a colour that is emitted L times.
- R3: A control byte with bit 7 = 1 is a literal span. Its bits 6:0 give a count L, where 0 means 128. The next L bytes are emitted as pixels in the order received.
- R4: `pix_transp` is high exactly when the emitted pixel value is 0.
- R5: `pix_eol` is high on every pixel whose column is width−1. Spans may continue across line ends.
- R6: `pix_eoi` is high on the width×height-th pixel. From the next cycle `done` is high, no further pixel is emitted, and any further input bytes are accepted and discarded.
- R7: A `start` pulse returns the decoder to header parsing from any state. It clears `done` and abandons any pending span.
- R8: While `pix_valid` is high and `pix_ready` is low, the offered pixel and its flags are held and no input byte is lost.
- R9: A header whose width or height is zero leads straight to `done` with no pixel emitted.
- R10: A span that runs past the end of the image is cut short at the last image pixel.
- R11: Out of reset, `done` and `pix_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart decoding at a new header |
| in_data | input | 8 | Encoded stream byte |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| pix_data | output | 8 | Pixel value |
| pix_transp | output | 1 | Pixel is transparent (value 0) |
| pix_eol | output | 1 | Last pixel of a line |
| pix_eoi | output | 1 | Last pixel of the image |
| pix_valid | output | 1 | Pixel offered |
| pix_ready | input | 1 | Consumer takes the pixel this cycle |
| done | output | 1 | Image complete, input discarded |

## Verification
On every cycle, the assertions check four things:
- a run colour is held steady under back-pressure;
- an active span never has a zero count;
- the column stays inside the line;
- `done` follows the last pixel, stays set, and blocks pixel output until `start`, which clears it.

Only the bench scenarios can show the correct pixel sequence. These scenarios cover mixed spans crossing a line end, the length-0 encodings meaning 128, truncation at image end, discarded surplus bytes, zero-sized headers and a restart in mid-run.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_CTRL,
    ST_COLR,
    ST_RUN,
    ST_LIT,
    ST_DONE
  } dec_st_e;
endpackage

// File: rtl/rle_reset_sync.sv
module rle_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rle_raster_ctr.sv
module rle_raster_ctr #(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  output logic             eol,
  output logic             eoi
);
  logic [DIM_W-1:0] col_q, col_d;
  logic [DIM_W-1:0] row_q, row_d;
  logic             cnt_en;

  assign eol    = (col_q == width - 1'b1);
  assign eoi    = eol && (row_q == height - 1'b1);
  assign cnt_en = clear || step;

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (clear) begin
      col_d = '0;
      row_d = '0;
    end else if (step) begin
      if (eol) begin
        col_d = '0;
        row_d = row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (cnt_en) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  AST_COL_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && width != '0) |-> (col_q < width)); // R5
endmodule

// File: rtl/rle_span_fsm.sv
module rle_span_fsm
  import rle_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [BYTE_W-1:0] pix_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  input  logic              img_last,
  output logic [DIM_W-1:0]  width,
  output logic [DIM_W-1:0]  height,
  output logic              hdr_phase,
  output logic              done
);
  localparam int LEN_W  = BYTE_W - 1;
  localparam int SPAN_W = LEN_W + 1;
  localparam int HB     = DIM_W / BYTE_W;
  localparam int HDR_N  = 2 * HB;
  localparam int IDX_W  = $clog2(HDR_N);

  dec_st_e           st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DIM_W-1:0]  w_q, w_d, h_q, h_d, h_shift;
  logic [SPAN_W-1:0] span_q, span_d;
  logic [BYTE_W-1:0] col_q, col_d;
  logic              in_fire, pix_fire, hdr_last, dim_en, span_en, col_en;

  always_comb begin
    unique case (st_q)
      ST_RUN:  in_ready = 1'b0;
      ST_LIT:  in_ready = pix_ready;
      default: in_ready = 1'b1;
    endcase
    unique case (st_q)
      ST_RUN:  begin pix_valid = 1'b1;     pix_data = col_q;   end
      ST_LIT:  begin pix_valid = in_valid; pix_data = in_data; end
      default: begin pix_valid = 1'b0;     pix_data = '0;      end
    endcase
  end

  assign in_fire   = in_valid && in_ready;
  assign pix_fire  = pix_valid && pix_ready;
  assign hdr_last  = (idx_q == IDX_W'(HDR_N - 1));
  assign h_shift   = {in_data, h_q[DIM_W-1:BYTE_W]};
  assign width     = w_q;
  assign height    = h_q;
  assign hdr_phase = (st_q == ST_HDR);
  assign done      = (st_q == ST_DONE);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    w_d    = w_q;
    h_d    = h_q;
    span_d = span_q;
    col_d  = col_q;
    if (start) begin
      st_d  = ST_HDR;
      idx_d = '0;
    end else begin
      unique case (st_q)
        ST_HDR: if (in_fire) begin
          idx_d = idx_q + 1'b1;
          if (idx_q < IDX_W'(HB)) w_d = {in_data, w_q[DIM_W-1:BYTE_W]};
          else                    h_d = h_shift;
          if (hdr_last)
            st_d = (w_q == '0 || h_shift == '0) ? ST_DONE : ST_CTRL;
        end
        ST_CTRL: if (in_fire) begin
          span_d = (in_data[LEN_W-1:0] == '0) ? SPAN_W'(1 << LEN_W)
                                              : {1'b0, in_data[LEN_W-1:0]};
          st_d   = in_data[BYTE_W-1] ? ST_LIT : ST_COLR;
        end
        ST_COLR: if (in_fire) begin
          col_d = in_data;
          st_d  = ST_RUN;
        end
        ST_RUN, ST_LIT: if (pix_fire) begin
          span_d = span_q - 1'b1;
          if (img_last)                 st_d = ST_DONE;
          else if (span_q == SPAN_W'(1)) st_d = ST_CTRL;
        end
        default: ;
      endcase
    end
  end

  assign dim_en  = (st_q == ST_HDR) && in_fire && !start;
  assign span_en = !start && (((st_q == ST_CTRL) && in_fire) || pix_fire);
  assign col_en  = !start && (st_q == ST_COLR) && in_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      idx_q  <= '0;
      w_q    <= '0;
      h_q    <= '0;
      span_q <= '0;
      col_q  <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (dim_en) begin
        w_q <= w_d;
        h_q <= h_d;
      end
      if (span_en) span_q <= span_d;
      if (col_en)  col_q  <= col_d;
    end
  end

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !pix_ready && !start) |=> (pix_valid && $stable(pix_data))); // R8
  AST_SPAN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN || st_q == ST_LIT) |-> (span_q != '0)); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fire && img_last && !start) |=> done); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !pix_valid)); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !pix_valid)); // R7
endmodule

// File: rtl/rle_pix_decoder.sv
module rle_pix_decoder
  import rle_pkg::*;
#(
  parameter int DIM_W    = 16,
  parameter int RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [BYTE_W-1:0] pix_data,
  output logic              pix_transp,
  output logic              pix_eol,
  output logic              pix_eoi,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic              done
);
  logic             rst_sync_n;
  logic [DIM_W-1:0] width, height;
  logic             hdr_phase, eol, eoi;

  rle_reset_sync #(.STAGES(RST_SYNC)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rle_span_fsm #(.DIM_W(DIM_W)) i_fsm (
    .clk(clk), .rst_n(rst_sync_n), .start(start),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .img_last(eoi), .width(width), .height(height),
    .hdr_phase(hdr_phase), .done(done)
  );

  rle_raster_ctr #(.DIM_W(DIM_W)) i_raster (
    .clk(clk), .rst_n(rst_sync_n), .clear(start || hdr_phase),
    .step(pix_valid && pix_ready), .width(width), .height(height),
    .eol(eol), .eoi(eoi)
  );

  assign pix_transp = pix_valid && (pix_data == '0);
  assign pix_eol    = pix_valid && eol;
  assign pix_eoi    = pix_valid && eoi;
endmodule

// File: tb/test_rle_pix_decoder.sv
`timescale 1ns/1ps
module test_rle_pix_decoder;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, pix_ready = 1'b1;
  logic in_ready, pix_transp, pix_eol, pix_eoi, pix_valid, done;
  logic [7:0] pix_data;
  int checks = 0, failures = 0, cyc_all = 0;

  logic [7:0] sbuf [0:299];
  logic [7:0] edat [0:199];
  logic       eeol [0:199];
  logic       eeoi [0:199];

  // header 3x2; run 2 of 5; literal 3 (0,7,9) across line end; run len0 (128) of 4 cut to 1; surplus bytes
  localparam logic [7:0] STIM1 [14] = '{8'h03, 8'h00, 8'h02, 8'h00, 8'h02, 8'h05,
    8'h83, 8'h00, 8'h07, 8'h09, 8'h00, 8'h04, 8'hAA, 8'hBB};
  // {eoi, eol, data}
  localparam logic [9:0] EXP1 [6] = '{10'h005, 10'h005, 10'h100, 10'h007, 10'h009, 10'h304};

  always #4 clk = ~clk;

  rle_pix_decoder i_rle_pix_decoder (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .pix_data(pix_data), .pix_transp(pix_transp), .pix_eol(pix_eol),
    .pix_eoi(pix_eoi), .pix_valid(pix_valid), .pix_ready(pix_ready), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    #1;
  endtask

  // rmode: 0 always ready, 1 stalls every third cycle, 2 never ready
  task automatic run_stream(input int n, input int nexp, input int rmode, input string tag);
    int idx = 0, k = 0, cyc = 0;
    logic held = 1'b0;
    logic [7:0] hd = '0;
    while ((idx < n || k < nexp) && cyc < 5000) begin
      @(negedge clk);
      in_valid  = (idx < n);
      in_data   = (idx < n) ? sbuf[idx] : 8'h00;
      pix_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 != 1) : 1'b0;
      #1;
      if (held) chk(pix_valid && pix_data == hd, "R8 held pixel", pix_data, hd);
      held = pix_valid && !pix_ready;
      hd   = pix_data;
      if (pix_valid && pix_ready) begin
        if (k < nexp) begin
          chk(pix_data == edat[k], tag, pix_data, edat[k]);
          chk(pix_eol == eeol[k], "R5 eol", pix_eol, eeol[k]);
          chk(pix_eoi == eeoi[k], "R6 eoi", pix_eoi, eeoi[k]);
          chk(pix_transp == (pix_data == 8'h00), "R4 transp", pix_transp, pix_data == 8'h00);
        end else begin
          chk(1'b0, "R6 extra pixel", k, nexp);
        end
        k++;
      end
      if (in_valid && in_ready) idx++;
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(k == nexp, {tag, " count"}, k, nexp);
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_all, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(done == 1'b0, "R11 done", done, 0);
    chk(pix_valid == 1'b0, "R11 pix_valid", pix_valid, 0);
    chk(in_ready == 1'b1, "R11 in_ready", in_ready, 1);

    // vector table: mixed spans, line crossing, truncation, surplus input
    for (int i = 0; i < 14; i++) sbuf[i] = STIM1[i];
    for (int i = 0; i < 6; i++) begin
      edat[i] = EXP1[i][7:0];
      eeol[i] = EXP1[i][8];
      eeoi[i] = EXP1[i][9];
    end
    run_stream(14, 6, 1, "R2 R3 R10 mixed");
    chk(done == 1'b1, "R6 done after image", done, 1);

    // R2 length 0 means 128
    pulse_start();
    chk(done == 1'b0, "R7 done cleared", done, 0);
    sbuf[0] = 8'h82; sbuf[1] = 8'h00; sbuf[2] = 8'h01; sbuf[3] = 8'h00;
    sbuf[4] = 8'h00; sbuf[5] = 8'h11; sbuf[6] = 8'h02; sbuf[7] = 8'h22;
    for (int i = 0; i < 130; i++) begin
      edat[i] = (i < 128) ? 8'h11 : 8'h22;
      eeol[i] = (i == 129);
      eeoi[i] = (i == 129);
    end
    run_stream(8, 130, 1, "R2 run128");
    chk(done == 1'b1, "R6 done run128", done, 1);

    // R3 literal count 0 means 128
    pulse_start();
    sbuf[0] = 8'h80; sbuf[1] = 8'h00; sbuf[2] = 8'h01; sbuf[3] = 8'h00; sbuf[4] = 8'h80;
    for (int i = 0; i < 128; i++) begin
      sbuf[5 + i] = 8'(i + 1);
      edat[i] = 8'(i + 1);
      eeol[i] = (i == 127);
      eeoi[i] = (i == 127);
    end
    run_stream(133, 128, 1, "R3 lit128");

    // R9 zero width, then zero height
    pulse_start();
    sbuf[0] = 8'h00; sbuf[1] = 8'h00; sbuf[2] = 8'h05; sbuf[3] = 8'h00;
    run_stream(4, 0, 0, "R9 zero width");
    chk(done == 1'b1, "R9 done zero width", done, 1);
    pulse_start();
    sbuf[0] = 8'h04; sbuf[1] = 8'h00; sbuf[2] = 8'h00; sbuf[3] = 8'h00;
    run_stream(4, 0, 0, "R9 zero height");
    chk(done == 1'b1, "R9 done zero height", done, 1);

    // R7 restart in the middle of a stalled run
    pulse_start();
    sbuf[0] = 8'h04; sbuf[1] = 8'h00; sbuf[2] = 8'h01; sbuf[3] = 8'h00;
    sbuf[4] = 8'h01; sbuf[5] = 8'h09;
    run_stream(6, 0, 2, "R8 stalled");
    chk(pix_valid == 1'b1 && pix_data == 8'h09, "R8 stalled run", pix_data, 9);
    pulse_start();
    chk(pix_valid == 1'b0, "R7 span dropped", pix_valid, 0);
    chk(done == 1'b0, "R7 not done", done, 0);
    sbuf[0] = 8'h01; sbuf[1] = 8'h00; sbuf[2] = 8'h01; sbuf[3] = 8'h00;
    sbuf[4] = 8'h01; sbuf[5] = 8'h07;
    edat[0] = 8'h07; eeol[0] = 1'b1; eeoi[0] = 1'b1;
    run_stream(6, 1, 0, "R7 R1 new image");
    chk(done == 1'b1, "R6 done new image", done, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule